// File: doc/BRIEF.md
# Peak-Valley Adaptive Threshold Slicer

This block sits after the moving-average filter of a zero-crossing frequency demodulator. The filter output is a stream of smoothed carrier-period samples. The block decides what each sample means as a data bit, using a decision level that adapts to the signal. A sliding window of the eight newest samples is examined on every accepted sample. A local extreme is recognised at the third-newest position when the older side of the window falls or rises steadily into it and the newer side turns back. A decision level is formed when an extreme of one kind follows an extreme of the other kind. That level is the midpoint of the latest peak and the latest valley. It is recomputed on every later change of kind, so a slowly moving DC offset caused by transmitter drift is followed.

Each sample is compared against the current level to give a raw decision. Twelve decisions make up one bit period. A majority count over each group removes isolated wrong decisions, and the result is issued as one bit with a one-cycle strobe. Samples arrive with a valid strobe. Idle cycles between samples are allowed.

Top module: `pvt_slicer`

## Requirements
- R1: While reset is applied and after it is released, the threshold output is 0, the threshold-valid flag is 0, the bit strobe is 0 and the bit output is 0.
- R2: A valley is recognised once at least 8 samples have been accepted since reset. With W0 the newest and W7 the oldest window sample, it requires W7>=W6>=W5>=W4>=W3>=W2 and W2<=W1<=W0. The valley value is W2.
- R3: A peak is recognised under the same fill condition. It requires W7<=W6<=...<=W2 and W2>=W1>=W0, and the peak value is W2. A window in which both patterns hold (all equal) counts as neither.
- R4: When a peak follows a valley, or a valley follows a peak, the threshold is loaded with (peak + valley) >> 1, computed without overflow. The threshold-valid flag is then set. A valley detected with no earlier peak, or the reverse, leaves the flag low.
- R5: Each accepted sample gives one decision. The decision is 1 only when the threshold is valid and the sample is strictly greater than the threshold in force before that sample's own update. Otherwise it is 0.
- R6: Decisions are grouped in twelves counted from reset. At the twelfth decision of a group, the bit strobe pulses for one cycle. The bit is 1 when 7 or more of the 12 decisions are 1, and 0 when 6 or fewer are. The bit output holds its value between strobes.
- R7: Threshold, valid flag and bit strobe for a sample change on the second rising edge after the edge that accepts the sample. They do not change on the first.
- R8: Once set, the threshold-valid flag stays set until reset. The threshold keeps its value between updates, including across samples that produce no alternation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_i | input | W (10) | Smoothed period sample, unsigned |
| smp_vld_i | input | 1 | Sample accepted on this rising edge |
| thr_o | output | W (10) | Current decision threshold |
| thr_vld_o | output | 1 | Threshold has been formed at least once |
| bit_o | output | 1 | Majority-voted bit, held between strobes |
| bit_vld_o | output | 1 | One-cycle strobe marking a new bit |

## Verification
A sample taken on one rising edge is shifted into the window there. Its detection, threshold update and decision take effect on the next rising edge. Every result for that sample is therefore due two edges after it was accepted. The bench drives each sample for one cycle, then reads all outputs on the falling edge after that second rising edge. It also reads the bit strobe one falling edge earlier, to confirm that no result appears a cycle too soon. The expected thresholds and votes are worked out by hand from the sample sequence, following the window and midpoint rules.

// File: rtl/pvt_pkg.sv
package pvt_pkg;

  // Kind of the most recently recognised local extreme.
  typedef enum logic [1:0] {
    EXT_NONE   = 2'd0,
    EXT_PEAK   = 2'd1,
    EXT_VALLEY = 2'd2
  } ext_kind_e;

  // Midpoint of two unsigned values; the sum keeps one extra bit.
  function automatic logic [15:0] mid_point(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] sum;
    sum = {1'b0, a} + {1'b0, b};
    return sum[16:1];
  endfunction

endpackage

// File: rtl/pvt_window.sv
module pvt_window #(
  parameter int W    = 10,
  parameter int TAPS = 8,
  parameter int MID  = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] smp_i,
  input  logic         vld_i,
  output logic         new_o,
  output logic [W-1:0] newest_o,
  output logic [W-1:0] mid_o,
  output logic         peak_o,
  output logic         valley_o
);

  localparam int FW = $clog2(TAPS + 1);
  localparam int NC = TAPS - 1;

  logic [W-1:0]  win_q [TAPS];
  logic [W-1:0]  win_d [TAPS];
  logic [FW-1:0] fill_q, fill_d;
  logic          new_q, new_d;
  logic [NC-1:0] older_ge;
  logic [NC-1:0] older_le;
  logic          full;
  logic          is_valley, is_peak;

  // next state: shift on each accepted sample, count fill up to TAPS
  always_comb begin
    for (int k = 0; k < TAPS; k++) win_d[k] = win_q[k];
    fill_d = fill_q;
    new_d  = vld_i;
    if (vld_i) begin
      win_d[0] = smp_i;
      for (int k = 1; k < TAPS; k++) win_d[k] = win_q[k-1];
      if (fill_q != FW'(TAPS)) fill_d = fill_q + FW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < TAPS; k++) win_q[k] <= '0;
      fill_q <= '0;
      new_q  <= 1'b0;
    end else begin
      for (int k = 0; k < TAPS; k++) win_q[k] <= win_d[k];
      fill_q <= fill_d;
      new_q  <= new_d;
    end
  end

  // pairwise ordering between each tap and the next older one
  for (genvar k = 0; k < NC; k++) begin : g_cmp
    assign older_ge[k] = (win_q[k+1] >= win_q[k]);
    assign older_le[k] = (win_q[k+1] <= win_q[k]);
  end

  assign full      = (fill_q == FW'(TAPS));
  assign is_valley = (&older_ge[NC-1:MID]) & (&older_le[MID-1:0]);
  assign is_peak   = (&older_le[NC-1:MID]) & (&older_ge[MID-1:0]);

  assign new_o    = new_q;
  assign newest_o = win_q[0];
  assign mid_o    = win_q[MID];
  assign valley_o = new_q & full & is_valley & ~is_peak;
  assign peak_o   = new_q & full & is_peak & ~is_valley;

endmodule

// File: rtl/pvt_track.sv
module pvt_track
  import pvt_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         peak_i,
  input  logic         valley_i,
  input  logic [W-1:0] mid_i,
  output logic [W-1:0] thr_o,
  output logic         thr_vld_o
);

  logic [W-1:0] pk_q, pk_d;
  logic [W-1:0] vl_q, vl_d;
  logic [W-1:0] thr_q, thr_d;
  logic         tv_q, tv_d;
  ext_kind_e    last_q, last_d;
  logic [15:0]  avg_pk, avg_vl;

  assign avg_pk = mid_point(16'(mid_i), 16'(vl_q));
  assign avg_vl = mid_point(16'(pk_q), 16'(mid_i));

  always_comb begin
    pk_d   = pk_q;
    vl_d   = vl_q;
    thr_d  = thr_q;
    tv_d   = tv_q;
    last_d = last_q;
    if (peak_i) begin
      pk_d   = mid_i;
      last_d = EXT_PEAK;
      if (last_q == EXT_VALLEY) begin
        thr_d = avg_pk[W-1:0];
        tv_d  = 1'b1;
      end
    end else if (valley_i) begin
      vl_d   = mid_i;
      last_d = EXT_VALLEY;
      if (last_q == EXT_PEAK) begin
        thr_d = avg_vl[W-1:0];
        tv_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pk_q   <= '0;
      vl_q   <= '0;
      thr_q  <= '0;
      tv_q   <= 1'b0;
      last_q <= EXT_NONE;
    end else begin
      pk_q   <= pk_d;
      vl_q   <= vl_d;
      thr_q  <= thr_d;
      tv_q   <= tv_d;
      last_q <= last_d;
    end
  end

  assign thr_o     = thr_q;
  assign thr_vld_o = tv_q;

endmodule

// File: rtl/pvt_vote.sv
module pvt_vote #(
  parameter int DPB = 12,
  parameter int MAJ = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dec_vld_i,
  input  logic dec_i,
  output logic bit_o,
  output logic bit_vld_o
);

  localparam int CW = $clog2(DPB + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] ones_q, ones_d;
  logic [CW-1:0] ones_sum;
  logic          bit_q, bit_d;
  logic          bv_q, bv_d;

  assign ones_sum = ones_q + CW'(dec_i);

  always_comb begin
    cnt_d  = cnt_q;
    ones_d = ones_q;
    bit_d  = bit_q;
    bv_d   = 1'b0;
    if (dec_vld_i) begin
      if (cnt_q == CW'(DPB - 1)) begin
        cnt_d  = '0;
        ones_d = '0;
        bit_d  = (ones_sum >= CW'(MAJ));
        bv_d   = 1'b1;
      end else begin
        cnt_d  = cnt_q + CW'(1);
        ones_d = ones_sum;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      ones_q <= '0;
      bit_q  <= 1'b0;
      bv_q   <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      ones_q <= ones_d;
      bit_q  <= bit_d;
      bv_q   <= bv_d;
    end
  end

  assign bit_o     = bit_q;
  assign bit_vld_o = bv_q;

endmodule

// File: rtl/pvt_slicer.sv
module pvt_slicer #(
  parameter int W    = 10,
  parameter int TAPS = 8,
  parameter int MID  = 2,
  parameter int DPB  = 12,
  parameter int MAJ  = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] smp_i,
  input  logic         smp_vld_i,
  output logic [W-1:0] thr_o,
  output logic         thr_vld_o,
  output logic         bit_o,
  output logic         bit_vld_o
);

  logic [1:0]   rsync_q;
  logic         rst_s;
  logic         win_new;
  logic [W-1:0] newest;
  logic [W-1:0] mid_val;
  logic         det_peak, det_valley;
  logic [W-1:0] thr;
  logic         thr_vld;
  logic         dec;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsync_q <= 2'b00;
    else         rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s = rsync_q[1];

  pvt_window #(.W(W), .TAPS(TAPS), .MID(MID)) u_win (
    .clk_i    (clk_i),
    .rst_ni   (rst_s),
    .smp_i    (smp_i),
    .vld_i    (smp_vld_i),
    .new_o    (win_new),
    .newest_o (newest),
    .mid_o    (mid_val),
    .peak_o   (det_peak),
    .valley_o (det_valley)
  );

  pvt_track #(.W(W)) u_trk (
    .clk_i     (clk_i),
    .rst_ni    (rst_s),
    .peak_i    (det_peak),
    .valley_i  (det_valley),
    .mid_i     (mid_val),
    .thr_o     (thr),
    .thr_vld_o (thr_vld)
  );

  // slice against the level in force before this sample's own update
  assign dec = thr_vld & (newest > thr);

  pvt_vote #(.DPB(DPB), .MAJ(MAJ)) u_vote (
    .clk_i     (clk_i),
    .rst_ni    (rst_s),
    .dec_vld_i (win_new),
    .dec_i     (dec),
    .bit_o     (bit_o),
    .bit_vld_o (bit_vld_o)
  );

  assign thr_o     = thr;
  assign thr_vld_o = thr_vld;

endmodule

// File: rtl/pvt_slicer_chk.sv
module pvt_slicer_chk #(
  parameter int W = 10
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         win_new,
  input logic [W-1:0] thr_o,
  input logic         thr_vld_o,
  input logic         bit_o,
  input logic         bit_vld_o
);

  // R8: valid flag never drops once set
  p_sticky_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_vld_o |=> thr_vld_o);

  // R8: level and flag move only on a cycle that processes a sample
  p_thr_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_new |=> ($stable(thr_o) && $stable(thr_vld_o)));

  // R7: a bit strobe follows a processed sample by one edge
  p_bit_timing_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_vld_o |-> $past(win_new));

  // R6: the strobe lasts a single cycle
  p_single_strobe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_vld_o |=> !bit_vld_o);

  // R5: without a valid level no bit can be one
  p_zero_before_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !thr_vld_o |-> !bit_o);

endmodule

bind pvt_slicer pvt_slicer_chk #(.W(W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_s),
  .win_new   (win_new),
  .thr_o     (thr_o),
  .thr_vld_o (thr_vld_o),
  .bit_o     (bit_o),
  .bit_vld_o (bit_vld_o)
);

// File: tb/sim_pvt_slicer.sv
module sim_pvt_slicer;

  localparam int W = 10;
  localparam int NV = 24;

  // sample, expected valid, expected threshold, expected strobe, expected bit
  localparam int VEC [NV][5] = '{
    '{100, 0,  0, 0, 0}, '{ 90, 0,  0, 0, 0}, '{ 80, 0,  0, 0, 0},
    '{ 70, 0,  0, 0, 0}, '{ 60, 0,  0, 0, 0}, '{ 50, 0,  0, 0, 0},
    '{ 60, 0,  0, 0, 0}, '{ 70, 0,  0, 0, 0}, '{ 80, 0,  0, 0, 0},
    '{ 90, 0,  0, 0, 0}, '{100, 0,  0, 0, 0}, '{ 90, 0,  0, 1, 0},
    '{ 80, 1, 75, 0, 0}, '{ 70, 1, 75, 0, 0}, '{ 60, 1, 75, 0, 0},
    '{ 40, 1, 75, 0, 0}, '{ 50, 1, 75, 0, 0}, '{ 60, 1, 70, 0, 0},
    '{ 80, 1, 70, 0, 0}, '{100, 1, 70, 0, 0}, '{120, 1, 70, 0, 0},
    '{110, 1, 70, 0, 0}, '{ 90, 1, 80, 0, 0}, '{ 85, 1, 80, 1, 0}
  };

  logic         clk;
  logic         rst_n;
  logic [W-1:0] smp;
  logic         smp_vld;
  logic [W-1:0] thr;
  logic         thr_vld;
  logic         bit_q;
  logic         bit_vld;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  logic early_bv;

  pvt_slicer u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .smp_i     (smp),
    .smp_vld_i (smp_vld),
    .thr_o     (thr),
    .thr_vld_o (thr_vld),
    .bit_o     (bit_q),
    .bit_vld_o (bit_vld)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      bad   = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=done", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one sample: accepted on edge A, results due on edge B
  task automatic send(input int v);
    @(negedge clk);
    smp     = W'(v);
    smp_vld = 1'b1;
    @(negedge clk);
    smp_vld  = 1'b0;
    early_bv = bit_vld;
    @(negedge clk);
  endtask

  task automatic check_reset(input string tag);
    chk(thr_vld == 1'b0, tag, int'(thr_vld), 0);
    chk(thr == '0,       tag, int'(thr), 0);
    chk(bit_vld == 1'b0, tag, int'(bit_vld), 0);
    chk(bit_q == 1'b0,   tag, int'(bit_q), 0);
  endtask

  initial begin
    rst_n   = 1'b0;
    smp     = '0;
    smp_vld = 1'b0;
    early_bv = 1'b0;
    repeat (3) @(negedge clk);
    check_reset("R1 during reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_reset("R1 after release");

    // table walk: R2 valley at entry 7, R3/R4 at 12, 17, 22, R5/R6 at 11 and 23
    for (int i = 0; i < NV; i++) begin
      send(VEC[i][0]);
      chk(early_bv == 1'b0, "R7 no early strobe", int'(early_bv), 0);
      chk(thr_vld == VEC[i][1][0], "R2/R4 threshold valid", int'(thr_vld), VEC[i][1]);
      if (VEC[i][1] != 0)
        chk(thr == W'(VEC[i][2]), "R4/R8 threshold value", int'(thr), VEC[i][2]);
      chk(bit_vld == VEC[i][3][0], "R6/R7 bit strobe", int'(bit_vld), VEC[i][3]);
      if (VEC[i][3] != 0)
        chk(bit_q == VEC[i][4][0], "R5/R6 voted bit", int'(bit_q), VEC[i][4]);
    end

    // R6: glitchy group with exactly 7 ones votes 1; R8: level held at 80
    for (int i = 0; i < 12; i++) begin
      send(((i % 2) == 0 || i == 11) ? 200 : 0);
      chk(thr == W'(80), "R8 threshold held", int'(thr), 80);
      if (i < 11) chk(bit_vld == 1'b0, "R6 no strobe mid group", int'(bit_vld), 0);
    end
    chk(bit_vld == 1'b1, "R6 strobe at twelfth", int'(bit_vld), 1);
    chk(bit_q == 1'b1,   "R6 seven ones give 1", int'(bit_q), 1);
    @(negedge clk);
    chk(bit_vld == 1'b0, "R6 strobe one cycle", int'(bit_vld), 0);
    chk(bit_q == 1'b1,   "R6 bit held", int'(bit_q), 1);

    // R1: reset in mid run clears everything
    rst_n = 1'b0;
    @(negedge clk);
    check_reset("R1 mid-run reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_reset("R1 after mid-run release");

    // R2: fewer than 8 samples after reset never detect
    send(50); send(40); send(30); send(20); send(30); send(40); send(50);
    chk(thr_vld == 1'b0, "R2 window not full", int'(thr_vld), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule